// File: doc/BRIEF.md
# Power-Loss Memory Protection Sequencer

This block sits on the platform side of a memory subsystem and turns a power-fail indication into an ordered handoff that keeps persistent memory contents safe. When the incoming power-fail level has been synchronised and has stayed high for a set number of cycles, the block raises a request for asynchronous DRAM refresh toward the memory controller. It then waits for two acknowledgements in a fixed order. First comes the flush of the protected write buffers. Then comes the report that every DIMM is in self-refresh.

Once both acknowledgements have arrived, the block pulses a completion strobe for one cycle. It then raises the trigger that starts the save on the non-volatile modules. When the modules report that the save is finished, it raises the request to cut all power rails and clocks.

Each wait has a bounded length. If an acknowledgement does not arrive in time, the block moves on anyway and records the event in a sticky timeout flag. Once the sequence has started it cannot be aborted. Power coming back has no effect, and only a reset returns the block to idle. All pins are plain control levels, so no stream handshake applies.

Top module: `pwrfail_seq`

## Requirements
- R1: After reset, adr_req, adr_done, save_go, rails_off and timeout_flag are all low.
- R2: pwr_fail_in passes through SYNC_STAGES flip-flops and must then be seen high for DEBOUNCE_CYC consecutive cycles. If pwr_fail_in goes high before clock edge k and stays high, adr_req is high after edge k+SYNC_STAGES+DEBOUNCE_CYC and low after the edge before it. A high pulse shorter than DEBOUNCE_CYC cycles causes no entry.
- R3: flush_done is acted on only while the block waits for the flush. A selfref_done that arrives before the flush is acknowledged is ignored.
- R4: adr_done is a single-cycle strobe. It rises on the edge after selfref_done is sampled in the self-refresh wait, which itself follows the flush acknowledgement. save_go is still low while adr_done is high.
- R5: save_go rises on the edge after the adr_done strobe and stays high until reset.
- R6: rails_off rises on the edge that samples save_done while save_go is high, and stays high until reset.
- R7: If no acknowledgement arrives within ACK_TIMEOUT cycles of entering a wait, the block moves on ACK_TIMEOUT edges after entry and sets timeout_flag, which stays high until reset. In the flush or self-refresh wait, the block jumps to save_go without an adr_done strobe. In the save wait, it raises rails_off.
- R8: Once adr_req is high, a low level on pwr_fail_in does not change the sequence.
- R9: adr_req stays high from its assertion until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_fail_in | input | 1 | Asynchronous power-fail level, high = power lost |
| flush_done | input | 1 | Protected write buffers flushed |
| selfref_done | input | 1 | All DIMMs in self-refresh |
| save_done | input | 1 | Module save finished |
| adr_req | output | 1 | Asynchronous DRAM refresh request |
| adr_done | output | 1 | One-cycle completion strobe |
| save_go | output | 1 | Module save trigger (level) |
| rails_off | output | 1 | Request to shut down rails and clocks |
| timeout_flag | output | 1 | Sticky: some wait expired |

## Verification
The bound checker enforces the ordering invariants on every cycle:
- adr_req and timeout_flag never drop.
- The completion strobe lasts exactly one cycle, and the save trigger follows it.
- A rising save trigger is caused either by that strobe or by a recorded timeout.
- rails_off appears only together with save_go.
- Entry happens only after the debounced level was valid.

The bench scenarios cover what the checker cannot:
- the exact entry latency through the synchroniser and debounce stages;
- the rejection of a short glitch;
- the ignoring of an early self-refresh acknowledgement and of power returning;
- the exact cycle on which each timeout fires.

// File: rtl/pwrfail_seq_pkg.sv
package pwrfail_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FLUSH_W = 3'd1,
    ST_SREF_W  = 3'd2,
    ST_CMPL    = 3'd3,
    ST_SAVE    = 3'd4,
    ST_OFF     = 3'd5
  } seq_st_t;
endpackage

// File: rtl/pf_sync_chain.sv
module pf_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/pf_debounce.sv
module pf_debounce #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic stable_out
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (!lvl_in)        run_cnt <= '0;
    else if (run_cnt != HOLD_V) run_cnt <= run_cnt + 1'b1;
  end

  assign stable_out = (run_cnt == HOLD_V);
endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tcnt <= '0;
    else if (clr)             tcnt <= '0;
    else if (en && !expired)  tcnt <= tcnt + 1'b1;
  end

  assign expired = (tcnt == LAST);
endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
  import pwrfail_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4,
  parameter int ACK_TIMEOUT  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_in,
  input  logic flush_done,
  input  logic selfref_done,
  input  logic save_done,
  output logic adr_req,
  output logic adr_done,
  output logic save_go,
  output logic rails_off,
  output logic timeout_flag
);
  logic    pf_synced;
  logic    pf_stable;
  logic    waiting;
  logic    tmo_exp;
  logic    tmo_hit;
  logic    ack_now;
  seq_st_t st, nxt;

  pf_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pwr_fail_in), .q_out(pf_synced)
  );

  pf_debounce #(.HOLD(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .lvl_in(pf_synced), .stable_out(pf_stable)
  );

  ack_timer #(.LIMIT(ACK_TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(nxt != st), .en(waiting), .expired(tmo_exp)
  );

  assign waiting = (st == ST_FLUSH_W) || (st == ST_SREF_W) || (st == ST_SAVE);
  assign tmo_hit = waiting && tmo_exp;

  always_comb begin
    case (st)
      ST_FLUSH_W: ack_now = flush_done;
      ST_SREF_W:  ack_now = selfref_done;
      ST_SAVE:    ack_now = save_done;
      default:    ack_now = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:    if (pf_stable) nxt = ST_FLUSH_W;
      ST_FLUSH_W: if (ack_now) nxt = ST_SREF_W; else if (tmo_hit) nxt = ST_SAVE;
      ST_SREF_W:  if (ack_now) nxt = ST_CMPL;   else if (tmo_hit) nxt = ST_SAVE;
      ST_CMPL:    nxt = ST_SAVE;
      ST_SAVE:    if (ack_now || tmo_hit) nxt = ST_OFF;
      ST_OFF:     nxt = ST_OFF;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  timeout_flag <= 1'b0;
    else if (tmo_hit && !ack_now) timeout_flag <= 1'b1;
  end

  assign adr_req   = (st != ST_IDLE);
  assign adr_done  = (st == ST_CMPL);
  assign save_go   = (st == ST_SAVE) || (st == ST_OFF);
  assign rails_off = (st == ST_OFF);
endmodule

// File: rtl/pwrfail_seq_chk.sv
module pwrfail_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pf_stable,
  input logic adr_req,
  input logic adr_done,
  input logic save_go,
  input logic rails_off,
  input logic timeout_flag
);
  // R9
  adr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_req |=> adr_req);
  // R2
  adr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adr_req) |-> $past(pf_stable));
  // R4
  cmpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_done |=> !adr_done);
  // R4
  cmpl_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_done |-> (adr_req && !save_go));
  // R5
  save_after_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_done |=> save_go);
  // R7
  save_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_go) |-> ($past(adr_done) || timeout_flag));
  // R6
  rails_need_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rails_off |-> save_go);
  // R6
  rails_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rails_off |=> rails_off);
  // R7
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);
endmodule

bind pwrfail_seq pwrfail_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pf_stable(pf_stable), .adr_req(adr_req),
  .adr_done(adr_done), .save_go(save_go), .rails_off(rails_off),
  .timeout_flag(timeout_flag)
);

// File: tb/pwrfail_seq_test.sv
module pwrfail_seq_test;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int TMO  = 32;
  localparam int LAT  = SYNC + DEB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail_in = 1'b0, flush_done = 1'b0, selfref_done = 1'b0, save_done = 1'b0;
  logic adr_req, adr_done, save_go, rails_off, timeout_flag;

  always #5 clk = ~clk;

  pwrfail_seq #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYC(DEB), .ACK_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_in(pwr_fail_in), .flush_done(flush_done),
    .selfref_done(selfref_done), .save_done(save_done), .adr_req(adr_req),
    .adr_done(adr_done), .save_go(save_go), .rails_off(rails_off),
    .timeout_flag(timeout_flag)
  );

  // vector order: {adr_req, adr_done, save_go, rails_off, timeout_flag}
  typedef struct {
    int         at;
    logic [4:0] vec;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  wire [4:0] obs = {adr_req, adr_done, save_go, rails_off, timeout_flag};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input logic [4:0] v, input string tag);
    exp_t e;
    e.at = at; e.vec = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic go_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      checks++;
      if (exp_q[0].at != cyc || obs !== exp_q[0].vec) begin
        fails++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b", exp_q[0].tag, cyc, obs, exp_q[0].vec);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    pwr_fail_in = 0; flush_done = 0; selfref_done = 0; save_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, 5'b00000, "R1 reset state");
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int at, input int which);
    go_to(at);
    case (which)
      0: flush_done = 1;
      1: selfref_done = 1;
      default: save_done = 1;
    endcase
    @(negedge clk);
    flush_done = 0; selfref_done = 0; save_done = 0;
  endtask

  task automatic finish_run;
    go_to(cyc + 3);
    if (exp_q.size() > 0) begin
      fails += exp_q.size();
      checks += exp_q.size();
      $display("FAIL leftover expectations actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // normal ordered sequence
    do_reset();
    n = cyc;
    push(n + LAT - 1, 5'b00000, "R2 no request before debounce");
    push(n + LAT,     5'b10000, "R2 request after debounce");
    push(n + LAT + 5, 5'b10000, "R3 early selfref ignored");
    push(n + LAT + 6, 5'b11000, "R4 completion strobe");
    push(n + LAT + 7, 5'b10100, "R5 save trigger after strobe");
    push(n + LAT + 9, 5'b10100, "R8 power return ignored");
    push(n + LAT + 10, 5'b10110, "R6 rails off after save");
    push(n + LAT + 18, 5'b10110, "R9 outputs held");
    pwr_fail_in = 1;
    pulse(n + LAT + 1, 1);
    go_to(n + LAT + 2);
    pwr_fail_in = 0;
    pulse(n + LAT + 3, 0);
    pulse(n + LAT + 5, 1);
    pulse(n + LAT + 9, 2);
    go_to(n + LAT + 19);

    // glitch shorter than debounce
    do_reset();
    n = cyc;
    push(n + LAT + 10, 5'b00000, "R2 glitch rejected");
    pwr_fail_in = 1;
    go_to(n + DEB - 1);
    pwr_fail_in = 0;
    go_to(n + LAT + 11);

    // flush timeout, then save timeout
    do_reset();
    n = cyc;
    push(n + LAT + TMO - 1,       5'b10000, "R7 no early flush timeout");
    push(n + LAT + TMO,           5'b10101, "R7 flush timeout forces save");
    push(n + LAT + 2*TMO - 1,     5'b10101, "R7 save wait still open");
    push(n + LAT + 2*TMO,         5'b10111, "R7 save timeout rails off");
    pwr_fail_in = 1;
    go_to(n + LAT + 2*TMO + 1);

    // selfref timeout after flush ack
    do_reset();
    n = cyc;
    push(n + LAT + 1,             5'b10000, "R3 flush accepted");
    push(n + LAT + 2 + TMO - 1,   5'b10000, "R7 no early selfref timeout");
    push(n + LAT + 2 + TMO,       5'b10101, "R7 selfref timeout no strobe");
    push(n + LAT + 2 + TMO + 4,   5'b10111, "R6 rails off after save");
    pwr_fail_in = 1;
    pulse(n + LAT + 1, 0);
    pulse(n + LAT + 2 + TMO + 3, 2);
    go_to(n + LAT + 2 + TMO + 5);

    finish_run();
  end
endmodule